// File: doc/BRIEF.md
# Packed Rounding Shift and Pack Unit

This block performs right shifts on packed data held in a 32-bit operand. It has three functions. The first shifts four signed byte lanes arithmetically, with optional rounding. The second shifts two unsigned halfword lanes logically. The third reduces two signed 32-bit words to halfwords and packs them into one word: each word is shifted arithmetically, rounding is optional, and the low halves of the two results are joined. Rounding looks at the last bit that the shift discards and adds one when that bit is set. A shift count of zero passes the data through and skips rounding.

For the byte and halfword functions, the count comes either from an immediate field or from the low bits of a second operand. The selection is made per operation. The result is registered, so a result appears one clock after its operands are presented. Register-file access and instruction decode belong to the surrounding datapath.

Top module: `pkd_rshift_pack`

## Requirements
- R1: A synchronous active-high reset clears `result` to zero. Outside reset, `result` shows the function of the inputs sampled at the previous rising clock edge.
- R2: With `func_sel`=0, each 8-bit lane of `opnd_a` is treated as signed and shifted arithmetically right by `shamt[2:0]` (0 to 7). Lane k occupies bits 8k+7:8k of both the input and the output.
- R3: With `round_en`=1 and a nonzero count s, a byte lane or pack word result is the shifted value plus one whenever bit s-1 of the original value is 1. The sum is then cut to the width of the lane or word.
- R4: A count of zero returns each lane or word unchanged, whatever `round_en` is.
- R5: With `func_sel`=1, each 16-bit lane of `opnd_a` is treated as unsigned and shifted logically right by `shamt[3:0]` (0 to 15), with zero fill. `round_en` has no effect.
- R6: With `func_sel`=2, `opnd_a` and `opnd_b` are both shifted arithmetically by `shamt[4:0]` under the rule of R3. The low 16 bits of the reduced `opnd_a` go to `result[31:16]`, and the low 16 bits of the reduced `opnd_b` go to `result[15:0]`.
- R7: When `var_amt`=1, the byte and halfword functions take their count from `opnd_b[2:0]` and `opnd_b[3:0]` respectively, and ignore `shamt`. The results equal the immediate form with the same count. The pack function ignores `var_amt`.
- R8: With `func_sel`=3, `result` is zero.
- R9: Each byte or halfword lane result depends only on the same lane of `opnd_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| func_sel | input | 2 | 0 byte arithmetic, 1 halfword logical, 2 word pack, 3 none |
| round_en | input | 1 | Enables rounding in the byte and pack functions |
| var_amt | input | 1 | Takes the count from `opnd_b` for the byte and halfword functions |
| opnd_a | input | 32 | Lane data; high-half word for pack |
| opnd_b | input | 32 | Low-half word for pack; count source when `var_amt`=1 |
| shamt | input | 5 | Immediate shift count |
| result | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after its operands are applied. The bench drives inputs on a falling edge and reads `result` on the next falling edge, once the single output register has captured the value. The checker compares each output with `$past` of the inputs one cycle earlier, so both sides observe the same one-cycle latency. For each count and each rounding setting, expected values come from integer arithmetic on the lane values.

// File: rtl/pkd_rshift_pkg.sv
package pkd_rshift_pkg;

    typedef enum logic [1:0] {
        FN_BYTE_SRA = 2'd0,
        FN_HALF_SRL = 2'd1,
        FN_PACK     = 2'd2,
        FN_NONE     = 2'd3
    } rsh_func_e;

    typedef struct packed {
        rsh_func_e   func;
        logic        rnd;
        logic [31:0] hi_word;
        logic [31:0] lo_word;
    } rsh_req_t;

    function automatic logic [31:0] join_halves(input logic [31:0] upper,
                                                input logic [31:0] lower);
        return {upper[15:0], lower[15:0]};
    endfunction

endpackage

// File: rtl/pkd_sra_round_lane.sv
module pkd_sra_round_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0]         val,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 rnd,
    output logic [W-1:0]         res
);
    logic [W-1:0] shifted;
    logic         guard;

    always_comb begin
        shifted = W'($signed(val) >>> amt);
        // last discarded bit decides the increment; zero count bypasses it
        guard   = rnd && (amt != '0) && val[amt - 1'b1];
        res     = shifted + {{(W-1){1'b0}}, guard};
    end
endmodule

// File: rtl/pkd_byte_sra.sv
module pkd_byte_sra #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0]         din,
    input  logic [$clog2(LANE_W)-1:0] amt,
    input  logic                      rnd,
    output logic [WORD_W-1:0]         dout
);
    localparam int NLANE = WORD_W / LANE_W;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        pkd_sra_round_lane #(.W(LANE_W)) u_lane (
            .val (din[k*LANE_W +: LANE_W]),
            .amt (amt),
            .rnd (rnd),
            .res (dout[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/pkd_half_srl.sv
module pkd_half_srl #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 16
) (
    input  logic [WORD_W-1:0]         din,
    input  logic [$clog2(LANE_W)-1:0] amt,
    output logic [WORD_W-1:0]         dout
);
    localparam int NLANE = WORD_W / LANE_W;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign dout[k*LANE_W +: LANE_W] = din[k*LANE_W +: LANE_W] >> amt;
    end
endmodule

// File: rtl/pkd_word_pack.sv
module pkd_word_pack
    import pkd_rshift_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         upper_in,
    input  logic [WORD_W-1:0]         lower_in,
    input  logic [$clog2(WORD_W)-1:0] amt,
    input  logic                      rnd,
    output logic [WORD_W-1:0]         dout
);
    logic [WORD_W-1:0] red_upper, red_lower;

    pkd_sra_round_lane #(.W(WORD_W)) u_upper (
        .val (upper_in), .amt (amt), .rnd (rnd), .res (red_upper)
    );
    pkd_sra_round_lane #(.W(WORD_W)) u_lower (
        .val (lower_in), .amt (amt), .rnd (rnd), .res (red_lower)
    );

    assign dout = join_halves(red_upper, red_lower);
endmodule

// File: rtl/pkd_rshift_pack.sv
module pkd_rshift_pack
    import pkd_rshift_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                func_sel,
    input  logic                      round_en,
    input  logic                      var_amt,
    input  logic [WORD_W-1:0]         opnd_a,
    input  logic [WORD_W-1:0]         opnd_b,
    input  logic [$clog2(WORD_W)-1:0] shamt,
    output logic [WORD_W-1:0]         result
);
    localparam int BSH_W = $clog2(BYTE_W);
    localparam int HSH_W = $clog2(HALF_W);

    rsh_req_t          req;
    logic [BSH_W-1:0]  byte_amt;
    logic [HSH_W-1:0]  half_amt;
    logic [WORD_W-1:0] byte_res, half_res, pack_res;
    logic [WORD_W-1:0] result_d;

    always_comb begin
        req.func    = rsh_func_e'(func_sel);
        req.rnd     = round_en;
        req.hi_word = opnd_a;
        req.lo_word = opnd_b;
        byte_amt    = var_amt ? opnd_b[BSH_W-1:0] : shamt[BSH_W-1:0];
        half_amt    = var_amt ? opnd_b[HSH_W-1:0] : shamt[HSH_W-1:0];
    end

    pkd_byte_sra #(.WORD_W(WORD_W), .LANE_W(BYTE_W)) u_bytes (
        .din (req.hi_word), .amt (byte_amt), .rnd (req.rnd), .dout (byte_res)
    );

    pkd_half_srl #(.WORD_W(WORD_W), .LANE_W(HALF_W)) u_halves (
        .din (req.hi_word), .amt (half_amt), .dout (half_res)
    );

    pkd_word_pack #(.WORD_W(WORD_W)) u_pack (
        .upper_in (req.hi_word), .lower_in (req.lo_word),
        .amt (shamt), .rnd (req.rnd), .dout (pack_res)
    );

    always_comb begin
        unique case (req.func)
            FN_BYTE_SRA: result_d = byte_res;
            FN_HALF_SRL: result_d = half_res;
            FN_PACK:     result_d = pack_res;
            default:     result_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= result_d;
    end
endmodule

// File: rtl/pkd_rshift_pack_chk.sv
module pkd_rshift_pack_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  func_sel,
    input logic        round_en,
    input logic        var_amt,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [4:0]  shamt,
    input logic [31:0] result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> result == 32'd0);

    // R8
    idle_func_chk: assert property (@(posedge clk) disable iff (rst)
        func_sel == 2'd3 |=> result == 32'd0);

    // R4
    byte_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (func_sel == 2'd0 && !var_amt && shamt[2:0] == 3'd0)
        |=> result == $past(opnd_a));

    // R4
    pack_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (func_sel == 2'd2 && shamt == 5'd0)
        |=> result == {$past(opnd_a[15:0]), $past(opnd_b[15:0])});

    // R5
    half_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (func_sel == 2'd1 && !var_amt && shamt[3:0] != 4'd0)
        |=> (result[31] == 1'b0 && result[15] == 1'b0));

    // R5
    half_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        func_sel == 2'd1
        |=> (result[31:16] <= $past(opnd_a[31:16]) && result[15:0] <= $past(opnd_a[15:0])));

    // R2
    byte_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (func_sel == 2'd0 && !round_en)
        |=> (result[31] == $past(opnd_a[31]) && result[23] == $past(opnd_a[23]) &&
             result[15] == $past(opnd_a[15]) && result[7]  == $past(opnd_a[7])));
endmodule

bind pkd_rshift_pack pkd_rshift_pack_chk u_chk (
    .clk (clk), .rst (rst), .func_sel (func_sel), .round_en (round_en),
    .var_amt (var_amt), .opnd_a (opnd_a), .opnd_b (opnd_b),
    .shamt (shamt), .result (result)
);

// File: tb/pkd_rshift_pack_bench.sv
module pkd_rshift_pack_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  func_sel;
    logic        round_en;
    logic        var_amt;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [4:0]  shamt;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pkd_rshift_pack u_pkd_rshift_pack (
        .clk (clk), .rst (rst), .func_sel (func_sel), .round_en (round_en),
        .var_amt (var_amt), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .shamt (shamt), .result (result)
    );

    function automatic logic [31:0] exp_bytes(input logic [31:0] a, input int s, input bit rnd);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            logic signed [7:0] lane;
            int v, q;
            lane = a[k*8 +: 8];
            v = lane;
            q = v >>> s;
            if (rnd && s != 0 && ((v >>> (s - 1)) & 1) == 1) q = q + 1;
            r[k*8 +: 8] = q[7:0];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_halves(input logic [31:0] a, input int s);
        logic [31:0] r = '0;
        for (int k = 0; k < 2; k++) begin
            int v;
            v = int'(a[k*16 +: 16]);
            v = v / (1 << s);
            r[k*16 +: 16] = v[15:0];
        end
        return r;
    endfunction

    function automatic logic [15:0] exp_word_low(input logic [31:0] w, input int s, input bit rnd);
        logic signed [31:0] sw;
        longint v, q;
        sw = w;
        v = sw;
        q = v >>> s;
        if (rnd && s != 0 && ((v >>> (s - 1)) & 1) == 1) q = q + 1;
        return q[15:0];
    endfunction

    task automatic apply(input logic [1:0] fn, input bit rnd, input bit vf,
                         input logic [31:0] a, input logic [31:0] b, input logic [4:0] s);
        @(negedge clk);
        func_sel = fn; round_en = rnd; var_amt = vf;
        opnd_a = a; opnd_b = b; shamt = s;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] expv);
        total++;
        if (result !== expv) begin
            bad++;
            $display("FAIL %s: got %h expected %h (fn=%0d rnd=%0d var=%0d a=%h b=%h s=%0d)",
                     req, result, expv, func_sel, round_en, var_amt, opnd_a, opnd_b, shamt);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R1: watchdog expired, got %h expected completion", result);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [31:0] byte_pats [3] = '{32'h807FFF01, 32'h7F80FF00, 32'hA55A3CC3};
    logic [31:0] half_pats [3] = '{32'h80007FFF, 32'hFFFF0001, 32'h8000FFFF};
    logic [31:0] pack_a    [3] = '{32'h7FFFFFFF, 32'h80000000, 32'h12345678};
    logic [31:0] pack_b    [3] = '{32'h80000000, 32'h7FFFFFFF, 32'hFEDCBA98};

    initial begin
        rst = 1'b1;
        func_sel = 2'd0; round_en = 1'b0; var_amt = 1'b0;
        opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF; shamt = 5'd0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4: byte arithmetic shift, every count, rounding off and on
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 8; s++) begin
                    apply(2'd0, bit'(r), 1'b0, byte_pats[p], 32'h0, 5'(s | 8));
                    check(s == 0 ? "R4 byte zero count" : (r == 1 ? "R3 byte round" : "R2 byte shift"),
                          exp_bytes(byte_pats[p], s, bit'(r)));
                end

        // R5 R4: halfword logical shift, rounding must not matter
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 16; s++) begin
                    apply(2'd1, bit'(r), 1'b0, half_pats[p], 32'h0, 5'(s | 16));
                    check(s == 0 ? "R4 half zero count" : "R5 half shift",
                          exp_halves(half_pats[p], s));
                end

        // R6 R3 R4: word pack, every count
        for (int p = 0; p < 3; p++)
            for (int r = 0; r < 2; r++)
                for (int s = 0; s < 32; s++) begin
                    apply(2'd2, bit'(r), bit'(p & 1), pack_a[p], pack_b[p], 5'(s));
                    check(s == 0 ? "R4 pack zero count" : (r == 1 ? "R3 R6 pack round" : "R6 pack"),
                          {exp_word_low(pack_a[p], s, bit'(r)), exp_word_low(pack_b[p], s, bit'(r))});
                end

        // R7: variable count from opnd_b, shamt set to a different value
        for (int r = 0; r < 2; r++)
            for (int s = 0; s < 8; s++) begin
                apply(2'd0, bit'(r), 1'b1, 32'h807FFF01, 32'hDEADBEE0 | 32'(s), 5'(7 - s));
                check("R7 byte variable", exp_bytes(32'h807FFF01, s, bit'(r)));
            end
        for (int s = 0; s < 16; s++) begin
            apply(2'd1, 1'b0, 1'b1, 32'h80007FFF, 32'hDEADBEE0 | 32'(s), 5'(15 - s));
            check("R7 half variable", exp_halves(32'h80007FFF, s));
        end

        // R8: unused function code
        apply(2'd3, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3);
        check("R8 idle code", 32'd0);

        // R9: lane isolation, neighbours change while lane 2 stays put
        apply(2'd0, 1'b1, 1'b0, 32'h00C00000, 32'h0, 5'd2);
        check("R9 lane isolation a", exp_bytes(32'h00C00000, 2, 1'b1));
        apply(2'd0, 1'b1, 1'b0, 32'h7FC0FF81, 32'h0, 5'd2);
        total++;
        if (result[23:16] !== 8'hF0) begin
            bad++;
            $display("FAIL R9: lane 2 got %h expected f0", result[23:16]);
        end
        apply(2'd1, 1'b0, 1'b0, 32'h00001234, 32'h0, 5'd4);
        check("R9 half isolation a", 32'h00000123);
        apply(2'd1, 1'b0, 1'b0, 32'hFFFF1234, 32'h0, 5'd4);
        check("R9 half isolation b", 32'h0FFF0123);

        // R1: reset in mid-stream clears the registered result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", 32'd0);
        rst = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule